// File: doc/BRIEF.md
# Load/Store Memory Access Unit

This unit carries out one data-memory operation at a time for an out-of-order core. The scheduler presents a request with an address, store data, an operation kind, a size code, an 11-bit instruction identifier and a reorder-buffer tag. The unit accepts the request, stays busy for a fixed number of cycles, and then completes it. A load returns a 32-bit value and the tag of its request. A store writes 1, 2 or 4 bytes and also reports its tag.

A two-bit status output tells the scheduler what the unit is doing. It reports busy, free with nothing to report, or free with a completed result. A new request can be accepted in the same cycle that a result is shown. Sub-word loads are sign-extended only for two particular identifier codes and zero-extended for all others. A flush input drops any operation in progress. For testing, the unit contains a small byte-addressable data array with little-endian byte order. Addresses wrap modulo the size of the array.

Top module: `lsu_mem_unit`

## Requirements
- R1: After reset, `status` is 1 (free, no result).
- R2: In a non-busy cycle with `req_kind` equal to 0, the next status is 1. A request with a nonzero `req_kind` and a legal size is accepted at the clock edge, and `status` becomes 0 (busy). After exactly LATENCY busy cycles, `status` shows 2 (result valid, free) for exactly one cycle.
- R3: `req_kind` 1 selects a load. The values 2 and 3 both select a store.
- R4: Size code 0, 1 or 2 selects 1, 2 or 4 bytes. A request with size code 3 is not accepted: the status stays 1 and the array is not written.
- R5: A byte load is sign-extended from bit 7 when `req_id` equals 11'h203. Any other identifier gives zero extension.
- R6: A halfword load is sign-extended from bit 15 when `req_id` equals 11'h283. Any other identifier gives zero extension.
- R7: A store writes only the low 1, 2 or 4 bytes of `req_wdata`, in little-endian order starting at the address. All other bytes keep their values. A word load assembles its bytes in the same order, wrapping past the top of the array.
- R8: A flush forces `status` to 1 on the next cycle. An aborted operation reports no result, and an aborted store leaves the array unchanged.
- R9: While `status` is 2, `done_tag` is the tag of the request that finished. `done_data` holds the load value, or 0 for a store.
- R10: A request presented in a cycle where `status` is 2 is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Drops any operation in progress |
| req_kind | input | 2 | 0 no request, 1 load, 2 or 3 store |
| req_size | input | 2 | Size code: access is 2**code bytes |
| req_id | input | 11 | Instruction identifier; selects sign extension |
| req_tag | input | 5 | Reorder-buffer tag of the request |
| req_addr | input | 32 | Byte address; low bits index the array |
| req_wdata | input | 32 | Store data |
| status | output | 2 | 0 busy, 1 free, 2 result valid and free |
| done_tag | output | 5 | Tag of the completed operation |
| done_data | output | 32 | Load result, or 0 for a store |

## Verification
The assertions assume that `req_kind` and `req_size` are known values in every cycle after reset. They also assume that `flush` is a clean level that can arrive in any state. To keep within this, the stimulus holds `req_kind` at 0 between requests and presents each request only in a non-busy cycle. Flush is raised for exactly one cycle while the unit is busy. The bench reads only array bytes that an earlier store has written, so no uninitialised storage reaches a compared result.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
   typedef enum logic [1:0] {
      ST_BUSY = 2'd0,
      ST_FREE = 2'd1,
      ST_DONE = 2'd2
   } lsu_status_e;

   localparam logic [1:0] KIND_NONE = 2'd0;
   localparam logic [1:0] KIND_LOAD = 2'd1;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;
   localparam logic [1:0] SZ_BAD  = 2'd3;
endpackage

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
   import lsu_pkg::*;
#(
   parameter int LATENCY = 3,
   parameter int TAG_W   = 5,
   parameter int ID_W    = 11,
   parameter int XLEN    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [1:0]        req_kind,
   input  logic [1:0]        req_size,
   input  logic [ID_W-1:0]   req_id,
   input  logic [TAG_W-1:0]  req_tag,
   input  logic [XLEN-1:0]   req_addr,
   input  logic [XLEN-1:0]   req_wdata,
   output lsu_status_e       state,
   output logic              fire,
   output logic              op_load,
   output logic [1:0]        op_size,
   output logic [ID_W-1:0]   op_id,
   output logic [TAG_W-1:0]  op_tag,
   output logic [XLEN-1:0]   op_addr,
   output logic [XLEN-1:0]   op_wdata
);
   localparam int CNT_W = (LATENCY > 1) ? $clog2(LATENCY) : 1;
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

   if (LATENCY < 1) begin : g_bad_latency
      $error("lsu_ctrl: LATENCY must be at least 1");
   end

   logic [CNT_W-1:0] cnt;
   logic             take;

   assign take = (state != ST_BUSY) && (req_kind != KIND_NONE) && (req_size != SZ_BAD);
   assign fire = (state == ST_BUSY) && (cnt == '0) && !flush;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_FREE;
         cnt      <= '0;
         op_load  <= 1'b0;
         op_size  <= '0;
         op_id    <= '0;
         op_tag   <= '0;
         op_addr  <= '0;
         op_wdata <= '0;
      end else if (flush) begin
         state <= ST_FREE;
         cnt   <= '0;
      end else if (state == ST_BUSY) begin
         if (cnt == '0) state <= ST_DONE;
         else           cnt   <= cnt - 1'b1;
      end else if (take) begin
         state    <= ST_BUSY;
         cnt      <= CNT_LOAD;
         op_load  <= (req_kind == KIND_LOAD);
         op_size  <= req_size;
         op_id    <= req_id;
         op_tag   <= req_tag;
         op_addr  <= req_addr;
         op_wdata <= req_wdata;
      end else begin
         state <= ST_FREE;
      end
   end

   AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      state != 2'd3); // R2
   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && state != ST_BUSY && req_kind != KIND_NONE && req_size != SZ_BAD)
      |=> state == ST_BUSY); // R10
   AST_IDLE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush && state != ST_BUSY && req_kind == KIND_NONE) |=> state == ST_FREE); // R2
   AST_BAD_SIZE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_BUSY && req_size == SZ_BAD) |=> state == ST_FREE); // R4
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_DONE |=> state != ST_DONE); // R2
   AST_FLUSH_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> state == ST_FREE); // R8
   AST_TAG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_BUSY |=> $stable(op_tag)); // R9
endmodule

// File: rtl/lsu_byte_array.sv
module lsu_byte_array
   import lsu_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [1:0]    size,
   input  logic [AW-1:0] addr,
   input  logic [31:0]   wdata,
   output logic [31:0]   rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 2 || AW > 12) begin : g_bad_aw
      $error("lsu_byte_array: AW must lie in 2..12");
   end

   logic [7:0] mem [DEPTH];
   logic [3:0] lane_en;

   always_comb begin
      case (size)
         SZ_BYTE: lane_en = 4'b0001;
         SZ_HALF: lane_en = 4'b0011;
         SZ_WORD: lane_en = 4'b1111;
         default: lane_en = 4'b0000;
      endcase
   end

   for (genvar b = 0; b < 4; b++) begin : g_rd_lane
      assign rdata[8*b +: 8] = mem[addr + AW'(b)];
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         for (int b = 0; b < 4; b++) begin
            if (lane_en[b]) mem[addr + AW'(b)] <= wdata[8*b +: 8];
         end
      end
   end
endmodule

// File: rtl/lsu_load_format.sv
module lsu_load_format
   import lsu_pkg::*;
#(
   parameter int              ID_W         = 11,
   parameter bit              SIGNED_LOADS = 1'b1,
   parameter logic [ID_W-1:0] SEXT_B_ID    = 11'h203,
   parameter logic [ID_W-1:0] SEXT_H_ID    = 11'h283
) (
   input  logic [1:0]      size,
   input  logic [ID_W-1:0] id,
   input  logic [31:0]     raw,
   output logic [31:0]     value
);
   logic sext_b, sext_h;

   if (SIGNED_LOADS) begin : g_signed
      assign sext_b = (id == SEXT_B_ID) && raw[7];
      assign sext_h = (id == SEXT_H_ID) && raw[15];
   end else begin : g_unsigned
      assign sext_b = 1'b0;
      assign sext_h = 1'b0;
   end

   always_comb begin
      case (size)
         SZ_BYTE: value = {{24{sext_b}}, raw[7:0]};
         SZ_HALF: value = {{16{sext_h}}, raw[15:0]};
         default: value = raw;
      endcase
   end
endmodule

// File: rtl/lsu_mem_unit.sv
module lsu_mem_unit
   import lsu_pkg::*;
#(
   parameter int LATENCY      = 3,
   parameter int ARRAY_AW     = 8,
   parameter int TAG_W        = 5,
   parameter int ID_W         = 11,
   parameter bit SIGNED_LOADS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [1:0]       req_kind,
   input  logic [1:0]       req_size,
   input  logic [ID_W-1:0]  req_id,
   input  logic [TAG_W-1:0] req_tag,
   input  logic [31:0]      req_addr,
   input  logic [31:0]      req_wdata,
   output logic [1:0]       status,
   output logic [TAG_W-1:0] done_tag,
   output logic [31:0]      done_data
);
   lsu_status_e      state;
   logic             fire, op_load;
   logic [1:0]       op_size;
   logic [ID_W-1:0]  op_id;
   logic [31:0]      op_addr, op_wdata, raw, fmt;
   logic             wr_en;

   lsu_ctrl #(.LATENCY(LATENCY), .TAG_W(TAG_W), .ID_W(ID_W), .XLEN(32)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .req_kind(req_kind), .req_size(req_size), .req_id(req_id),
      .req_tag(req_tag), .req_addr(req_addr), .req_wdata(req_wdata),
      .state(state), .fire(fire), .op_load(op_load), .op_size(op_size),
      .op_id(op_id), .op_tag(done_tag), .op_addr(op_addr), .op_wdata(op_wdata)
   );

   assign wr_en = fire && !op_load;

   lsu_byte_array #(.AW(ARRAY_AW)) u_array (
      .clk(clk), .wr_en(wr_en), .size(op_size),
      .addr(op_addr[ARRAY_AW-1:0]), .wdata(op_wdata), .rdata(raw)
   );

   lsu_load_format #(.ID_W(ID_W), .SIGNED_LOADS(SIGNED_LOADS)) u_fmt (
      .size(op_size), .id(op_id), .raw(raw), .value(fmt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    done_data <= '0;
      else if (fire) done_data <= op_load ? fmt : 32'd0;
   end

   assign status = state;

   AST_WRITE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (status == 2'd0 && !flush)); // R8
   AST_STORE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en) |=> done_data == 32'd0); // R9
endmodule

// File: tb/sim_lsu_mem_unit.sv
module sim_lsu_mem_unit;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [1:0]  req_kind = '0, req_size = '0;
   logic [10:0] req_id = '0;
   logic [4:0]  req_tag = '0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [1:0]  status;
   logic [4:0]  done_tag;
   logic [31:0] done_data;

   always #2 clk = ~clk;

   lsu_mem_unit #(.LATENCY(LAT)) u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .req_kind(req_kind),
      .req_size(req_size), .req_id(req_id), .req_tag(req_tag),
      .req_addr(req_addr), .req_wdata(req_wdata), .status(status),
      .done_tag(done_tag), .done_data(done_data)
   );

   typedef struct { logic [4:0] tag; logic [31:0] data; string req; } exp_t;
   exp_t        sb[$];
   logic [7:0]  mdl [256];
   int          n_chk = 0, n_bad = 0;
   bit          mon_on = 1'b0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] model_load(input logic [1:0] sz, input logic [10:0] id, input logic [7:0] a);
      logic [31:0] w;
      w = {mdl[8'(a + 8'd3)], mdl[8'(a + 8'd2)], mdl[8'(a + 8'd1)], mdl[a]};
      if (sz == 2'd0) return (id == 11'h203 && w[7])  ? {24'hFFFFFF, w[7:0]}  : {24'h0, w[7:0]};
      if (sz == 2'd1) return (id == 11'h283 && w[15]) ? {16'hFFFF, w[15:0]} : {16'h0, w[15:0]};
      return w;
   endfunction

   task automatic issue(input logic [1:0] k, input logic [1:0] sz, input logic [10:0] id,
                        input logic [4:0] tg, input logic [31:0] a, input logic [31:0] d,
                        input bit push, input string req);
      exp_t e;
      @(negedge clk);
      while (status == 2'd0) @(negedge clk);
      req_kind = k; req_size = sz; req_id = id; req_tag = tg; req_addr = a; req_wdata = d;
      if (push) begin
         e.tag = tg; e.req = req;
         if (k == 2'd1) e.data = model_load(sz, id, a[7:0]);
         else begin
            e.data = 32'd0;
            for (int b = 0; b < (1 << sz); b++) mdl[8'(a[7:0] + 8'(b))] = d[8*b +: 8];
         end
         sb.push_back(e);
      end
      @(negedge clk);
      req_kind = 2'd0;
   endtask

   // monitor / scoreboard
   int busy_run = 0;
   bit prev_done = 1'b0;
   always @(negedge clk) begin
      if (mon_on) begin
         if (status == 2'd2) begin
            chk(busy_run == LAT, "R2 busy length", busy_run, LAT);
            chk(!prev_done, "R2 single result cycle", {31'd0, prev_done}, 0);
            if (sb.size() == 0) chk(1'b0, "R8/R9 unexpected result", {27'd0, done_tag}, 0);
            else begin
               exp_t e;
               e = sb.pop_front();
               chk(done_tag == e.tag, {e.req, " R9 tag"}, done_tag, e.tag);
               chk(done_data == e.data, e.req, done_data, e.data);
            end
            busy_run = 0;
         end else if (status == 2'd0) busy_run++;
         else busy_run = 0;
         prev_done = (status == 2'd2);
      end
   end

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog R2: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(status == 2'd1, "R1 reset status", status, 1);
      mon_on = 1'b1;
      repeat (3) @(negedge clk);
      chk(status == 2'd1, "R2 idle stays free", status, 1);

      // seed stores, kind 2 and kind 3 both store (R3)
      issue(2'd2, 2'd2, 11'h0, 5'd1, 32'h10, 32'hF1E2D3C4, 1, "R7 word store");
      issue(2'd3, 2'd0, 11'h0, 5'd2, 32'h20, 32'h12345685, 1, "R3 kind3 byte store");
      issue(2'd2, 2'd1, 11'h0, 5'd3, 32'h30, 32'h123480FE, 1, "R7 half store");
      issue(2'd2, 2'd2, 11'h0, 5'd4, 32'h40, 32'hCAFE0123, 1, "R7 word store");
      issue(2'd2, 2'd0, 11'h0, 5'd5, 32'h24, 32'h0000007F, 1, "R7 byte store");
      // loads
      issue(2'd1, 2'd0, 11'h203, 5'd6, 32'h20, 0, 1, "R5 signed byte load");
      issue(2'd1, 2'd0, 11'h003, 5'd7, 32'h20, 0, 1, "R5 zero byte load");
      issue(2'd1, 2'd0, 11'h203, 5'd8, 32'h24, 0, 1, "R5 positive byte load");
      issue(2'd1, 2'd1, 11'h283, 5'd9, 32'h30, 0, 1, "R6 signed half load");
      issue(2'd1, 2'd1, 11'h083, 5'd10, 32'h30, 0, 1, "R6 zero half load");
      issue(2'd1, 2'd1, 11'h283, 5'd11, 32'h12, 0, 1, "R6 half load upper");
      issue(2'd1, 2'd2, 11'h103, 5'd12, 32'h10, 0, 1, "R7 word load");
      // partial overwrite, neighbours kept
      issue(2'd2, 2'd1, 11'h0, 5'd13, 32'h11, 32'hFFFF5A6B, 1, "R7 half store mid");
      issue(2'd1, 2'd2, 11'h103, 5'd14, 32'h10, 0, 1, "R7 neighbours kept");
      issue(2'd2, 2'd0, 11'h0, 5'd15, 32'h13, 32'hAAAAAA99, 1, "R7 byte store top");
      issue(2'd1, 2'd2, 11'h103, 5'd16, 32'h10, 0, 1, "R7 byte lane only");
      // wrap
      issue(2'd2, 2'd2, 11'h0, 5'd17, 32'hFE, 32'h89ABCDEF, 1, "R7 wrap store");
      issue(2'd1, 2'd2, 11'h103, 5'd18, 32'hFE, 0, 1, "R7 wrap load");
      // illegal size
      issue(2'd2, 2'd3, 11'h0, 5'd19, 32'h40, 32'h55555555, 0, "R4");
      chk(status == 2'd1, "R4 size 3 not accepted", status, 1);
      issue(2'd1, 2'd2, 11'h103, 5'd20, 32'h40, 0, 1, "R4 array unchanged");
      // flush aborts a store
      issue(2'd2, 2'd2, 11'h0, 5'd21, 32'h40, 32'h77777777, 0, "R8");
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      chk(status == 2'd1, "R8 flush frees unit", status, 1);
      issue(2'd1, 2'd2, 11'h103, 5'd22, 32'h40, 0, 1, "R8 aborted store not written");
      // back to back with distinct tag (R10 implicitly via issue timing)
      issue(2'd1, 2'd0, 11'h0, 5'd23, 32'h41, 0, 1, "R10 back-to-back load");

      while (sb.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(status == 2'd1, "R2 free after last result", status, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule